// File: doc/BRIEF.md
# Voice Group Trigger Controller

This block turns a small set of trigger lines into start and stop commands for a voice playback sequencer. It can select one of 32 voice groups. In key mode, each group is named by a run of adjacent active keys on a ring of eight keys. A separate sequential button steps through the groups one at a time. In CPU mode, a five-bit address on the low keys is captured when a strobe line rises.

Every trigger pattern passes through a debouncer that counts sample ticks. The counting window is longer while the sequencer reports busy. After the debouncer, per-group option bits decide what happens to a trigger. They choose between edge and level triggering, between holdable and unholdable playback, and between retriggerable and non-retriggerable playback. A high level on the abort line ends playback at once and clears the block's trigger state.

Top module: `vgt_ctrl`

## Requirements
- R1: In key mode, a single accepted key `keys_i[n]` (n = 0..7) starts group index n. `group_o` always carries the group number minus one.
- R2: In key mode, a run of r cyclically adjacent keys (r = 2..4) whose lowest key in ring order is `keys_i[n]` starts index 8*(r-1)+n. Keys 7 and 0 are adjacent. Any other non-zero pattern starts nothing.
- R3: In CPU mode, a rising strobe starts the index held on `keys_i[4:0]`. `keys_i[7:5]` have no effect on the outputs or on debounce timing.
- R4: In key mode, with no key active, each accepted strobe rise starts the index held in a sequential pointer. The pointer then steps forward, wraps from 31 to 0, and is cleared by abort. In CPU mode the strobe never uses this pointer.
- R5: A new input pattern takes effect only after it stays unchanged for 128 counted ticks following the tick that first sees it. A change during that window restarts the count. Cycles without `tick_i` do not count.
- R6: While `seq_busy_i` is high, the window of R5 is 192 ticks.
- R7: If the current group is holdable (`trig_hold_i` bit = 1), a change of the accepted pattern away from the one that started playback gives a one-cycle `stop_o`. An unholdable group gives none.
- R8: A trigger during playback restarts playback if its group is retriggerable (`trig_rtg_i` bit = 1). Otherwise it gives no start, apart from the case in R9.
- R9: A non-retriggerable trigger during playback, for a level (`trig_edge_i` bit = 0) and unholdable group, is remembered. That group starts when `seq_done_i` arrives.
- R10: At `seq_done_i`, a level-triggered group whose starting pattern is still accepted starts again. An edge-triggered group returns to idle.
- R11: A high `abort_i` gives `stop_o` on the next cycle if playback was active. No start occurs while it is high. Keys still held afterwards must debounce again.
- R12: `start_o` and `stop_o` are single-cycle pulses registered one clock after the debounce acceptance edge. All outputs are low or zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| abort_i | input | 1 | High level aborts playback and clears trigger state |
| tick_i | input | 1 | Sample-rate tick enabling the debounce count |
| cpu_mode_i | input | 1 | 1 = address/strobe mode, 0 = key mode |
| keys_i | input | 8 | Key lines, or address on bits 4:0 in CPU mode |
| strobe_i | input | 1 | Sequential button in key mode, address strobe in CPU mode |
| seq_busy_i | input | 1 | Sequencer busy; selects the long debounce window |
| seq_done_i | input | 1 | Sequencer finished the current group |
| trig_edge_i | input | 32 | Per-group: 1 edge, 0 level |
| trig_hold_i | input | 32 | Per-group: 1 holdable |
| trig_rtg_i | input | 32 | Per-group: 1 retriggerable |
| start_o | output | 1 | Start pulse to the sequencer |
| stop_o | output | 1 | Stop pulse to the sequencer |
| group_o | output | 5 | Group index for the last start |

## Verification
Different kinds of fault show up at different times. A wrong debounce count or a wrong window choice moves the start pulse by whole ticks. This appears a few hundred cycles after a press, in the very first cycle the reference model expects the pulse. A corrupted sequential pointer or key decode gives a wrong `group_o` on the next start. A lost pending flag or wrong source pattern shows up only at the later `seq_done_i`, as a missing or extra restart or stop. The bench therefore runs each play to completion.

// File: rtl/vgt_pkg.sv
package vgt_pkg;
   typedef enum logic [1:0] {
      ACT_NONE,
      ACT_START,
      ACT_STOP,
      ACT_IDLE
   } vgt_act_e;
endpackage

// File: rtl/vgt_debounce.sv
module vgt_debounce #(
   parameter int W         = 9,
   parameter int SHORT_TCK = 128,
   parameter int LONG_TCK  = 192,
   parameter int CW        = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         tick_i,
   input  logic         long_i,
   input  logic [W-1:0] raw_i,
   output logic [W-1:0] stab_o
);
   logic [W-1:0]  cand_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] lim;

   assign lim = long_i ? CW'(LONG_TCK) : CW'(SHORT_TCK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cand_q <= '0;
         cnt_q  <= '0;
         stab_o <= '0;
      end else if (clr_i) begin
         cand_q <= '0;
         cnt_q  <= '0;
         stab_o <= '0;
      end else if (tick_i) begin
         if (raw_i != cand_q) begin
            cand_q <= raw_i;
            cnt_q  <= '0;
         end else if (cnt_q < lim) begin
            cnt_q <= cnt_q + CW'(1);
         end else begin
            stab_o <= cand_q;
         end
      end
   end

   AST_DEB_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !clr_i) |=> $stable(stab_o)); // R5
endmodule

// File: rtl/vgt_keymap.sv
module vgt_keymap #(
   parameter int NKEY   = 8,
   parameter int MAXRUN = 4,
   parameter int GW     = 5
) (
   input  logic [NKEY-1:0] keys_i,
   output logic            valid_o,
   output logic [GW-1:0]   idx_o
);
   localparam int NGRP = NKEY * MAXRUN;

   logic [NGRP-1:0] hit;

   for (genvar r = 1; r <= MAXRUN; r++) begin : g_run
      for (genvar n = 0; n < NKEY; n++) begin : g_pos
         localparam logic [2*NKEY-1:0] WIDE =
            (((2*NKEY)'(1) << r) - (2*NKEY)'(1)) << n;
         localparam logic [NKEY-1:0] PAT = WIDE[NKEY-1:0] | WIDE[2*NKEY-1:NKEY];
         assign hit[(r-1)*NKEY+n] = (keys_i == PAT);
      end
   end

   always_comb begin
      valid_o = |hit;
      idx_o   = '0;
      for (int i = 0; i < NGRP; i++) begin
         if (hit[i]) idx_o = GW'(i);
      end
   end
endmodule

// File: rtl/vgt_arbiter.sv
module vgt_arbiter
   import vgt_pkg::*;
#(
   parameter int NKEY   = 8,
   parameter int ADDR_W = 5,
   parameter int NGRP   = 32,
   parameter int GW     = 5,
   parameter int PW     = 9
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            abort_i,
   input  logic            cpu_mode_i,
   input  logic [PW-1:0]   stab_i,
   input  logic            kvalid_i,
   input  logic [GW-1:0]   kidx_i,
   input  logic            done_i,
   input  logic [NGRP-1:0] edge_i,
   input  logic [NGRP-1:0] hold_i,
   input  logic [NGRP-1:0] rtg_i,
   output logic            start_o,
   output logic            stop_o,
   output logic [GW-1:0]   group_o
);
   logic [PW-1:0] prv_q, src_q;
   logic          act_q, pend_q;
   logic [GW-1:0] cur_q, pg_q, ptr_q;

   logic          press, seq_press, release_ev, take_new, queue, strobe_rise;
   logic [GW-1:0] pg, nxt_g;
   vgt_act_e      act;

   always_comb begin
      strobe_rise = stab_i[NKEY] & ~prv_q[NKEY];
      press       = 1'b0;
      seq_press   = 1'b0;
      pg          = ptr_q;
      if (cpu_mode_i) begin
         press = strobe_rise;
         pg    = GW'(stab_i[ADDR_W-1:0]);
      end else if (|stab_i[NKEY-1:0]) begin
         press = kvalid_i & (stab_i[NKEY-1:0] != prv_q[NKEY-1:0]);
         pg    = kidx_i;
      end else begin
         press     = strobe_rise;
         seq_press = strobe_rise;
      end
      release_ev = act_q & (prv_q == src_q) & (stab_i != src_q);
      take_new   = press & (~act_q | rtg_i[pg]);
      queue      = press & act_q & ~rtg_i[pg] & ~edge_i[pg] & ~hold_i[pg];
      act        = ACT_NONE;
      nxt_g      = pg;
      if (take_new) begin
         act = ACT_START;
      end else if (release_ev && hold_i[cur_q]) begin
         act = ACT_STOP;
      end else if (done_i && act_q) begin
         if (pend_q || queue) begin
            act   = ACT_START;
            nxt_g = queue ? pg : pg_q;
         end else if (!edge_i[cur_q] && stab_i == src_q) begin
            act   = ACT_START;
            nxt_g = cur_q;
         end else begin
            act = ACT_IDLE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prv_q   <= '0;
         src_q   <= '0;
         act_q   <= 1'b0;
         pend_q  <= 1'b0;
         cur_q   <= '0;
         pg_q    <= '0;
         ptr_q   <= '0;
         start_o <= 1'b0;
         stop_o  <= 1'b0;
         group_o <= '0;
      end else begin
         start_o <= 1'b0;
         stop_o  <= 1'b0;
         if (abort_i) begin
            stop_o <= act_q;
            act_q  <= 1'b0;
            pend_q <= 1'b0;
            ptr_q  <= '0;
            prv_q  <= '0;
            src_q  <= '0;
         end else begin
            prv_q <= stab_i;
            if (seq_press) ptr_q <= (ptr_q == GW'(NGRP-1)) ? '0 : ptr_q + GW'(1);
            case (act)
               ACT_START: begin
                  start_o <= 1'b1;
                  group_o <= nxt_g;
                  cur_q   <= nxt_g;
                  src_q   <= stab_i;
                  act_q   <= 1'b1;
                  pend_q  <= 1'b0;
               end
               ACT_STOP: begin
                  stop_o <= 1'b1;
                  act_q  <= 1'b0;
                  pend_q <= 1'b0;
               end
               ACT_IDLE: begin
                  act_q  <= 1'b0;
                  pend_q <= 1'b0;
               end
               default: begin
                  if (queue) begin
                     pend_q <= 1'b1;
                     pg_q   <= pg;
                  end
               end
            endcase
         end
      end
   end

   AST_ABORT_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
      abort_i |=> !start_o); // R11
   AST_SEQ_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_press && !abort_i && ptr_q == GW'(NGRP-1)) |=> (ptr_q == '0)); // R4
   AST_STOP_ENDS_PLAY: assert property (@(posedge clk) disable iff (!rst_n)
      stop_o |-> !act_q); // R7
   AST_START_SETS_PLAY: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |-> (act_q && cur_q == group_o)); // R12
endmodule

// File: rtl/vgt_ctrl.sv
module vgt_ctrl #(
   parameter int NKEY      = 8,
   parameter int MAXRUN    = 4,
   parameter int ADDR_W    = 5,
   parameter int SHORT_TCK = 128,
   parameter int LONG_TCK  = 192,
   localparam int NGRP     = NKEY * MAXRUN,
   localparam int GW       = $clog2(NGRP)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            abort_i,
   input  logic            tick_i,
   input  logic            cpu_mode_i,
   input  logic [NKEY-1:0] keys_i,
   input  logic            strobe_i,
   input  logic            seq_busy_i,
   input  logic            seq_done_i,
   input  logic [NGRP-1:0] trig_edge_i,
   input  logic [NGRP-1:0] trig_hold_i,
   input  logic [NGRP-1:0] trig_rtg_i,
   output logic            start_o,
   output logic            stop_o,
   output logic [GW-1:0]   group_o
);
   localparam int PW = NKEY + 1;
   localparam int CW = $clog2(LONG_TCK + 1);
   localparam logic [NKEY-1:0] ADDR_MASK = NKEY'((1 << ADDR_W) - 1);

   if (MAXRUN >= NKEY) begin : g_bad_run
      $error("MAXRUN must be below NKEY");
   end
   if ((1 << ADDR_W) > NGRP || ADDR_W > NKEY) begin : g_bad_addr
      $error("ADDR_W too wide for the group count or key count");
   end
   if (LONG_TCK < SHORT_TCK) begin : g_bad_tck
      $error("LONG_TCK must not be below SHORT_TCK");
   end

   logic [PW-1:0] raw, stab;
   logic          kvalid;
   logic [GW-1:0] kidx;

   assign raw = {strobe_i, cpu_mode_i ? (keys_i & ADDR_MASK) : keys_i};

   vgt_debounce #(.W(PW), .SHORT_TCK(SHORT_TCK), .LONG_TCK(LONG_TCK), .CW(CW)) i_deb (
      .clk(clk), .rst_n(rst_n), .clr_i(abort_i), .tick_i(tick_i),
      .long_i(seq_busy_i), .raw_i(raw), .stab_o(stab)
   );

   vgt_keymap #(.NKEY(NKEY), .MAXRUN(MAXRUN), .GW(GW)) i_map (
      .keys_i(stab[NKEY-1:0]), .valid_o(kvalid), .idx_o(kidx)
   );

   vgt_arbiter #(.NKEY(NKEY), .ADDR_W(ADDR_W), .NGRP(NGRP), .GW(GW), .PW(PW)) i_arb (
      .clk(clk), .rst_n(rst_n), .abort_i(abort_i), .cpu_mode_i(cpu_mode_i),
      .stab_i(stab), .kvalid_i(kvalid), .kidx_i(kidx), .done_i(seq_done_i),
      .edge_i(trig_edge_i), .hold_i(trig_hold_i), .rtg_i(trig_rtg_i),
      .start_o(start_o), .stop_o(stop_o), .group_o(group_o)
   );
endmodule

// File: tb/test_vgt_ctrl.sv
`timescale 1ns/1ps
module test_vgt_ctrl;
   localparam int SHORT = 128;
   localparam int LONG  = 192;
   localparam int PLAY  = 1000;
   localparam logic [31:0] EDGE_OPT = 32'hFFFF_FFF5;
   localparam logic [31:0] HOLD_OPT = 32'h0000_0006;
   localparam logic [31:0] RTG_OPT  = 32'h0000_0010;

   logic clk = 1'b0, rst_n = 1'b0, abort = 1'b0, tick = 1'b0, cpu = 1'b0;
   logic [7:0] keys = '0;
   logic strobe = 1'b0, busy = 1'b0, done = 1'b0;
   logic start_o, stop_o;
   logic [4:0] group_o;

   vgt_ctrl i_vgt_ctrl (
      .clk(clk), .rst_n(rst_n), .abort_i(abort), .tick_i(tick), .cpu_mode_i(cpu),
      .keys_i(keys), .strobe_i(strobe), .seq_busy_i(busy), .seq_done_i(done),
      .trig_edge_i(EDGE_OPT), .trig_hold_i(HOLD_OPT), .trig_rtg_i(RTG_OPT),
      .start_o(start_o), .stop_o(stop_o), .group_o(group_o)
   );

   always #2.5 clk = ~clk;

   int vectors = 0, checks = 0, errs = 0;
   int n_start = 0, n_stop = 0, last_grp = -1, tcnt = 0, left = 0;
   string cur_req = "R12";

   // tick on three cycles out of four
   always @(negedge clk) begin
      tcnt++;
      tick = (tcnt % 4) != 0;
   end

   // behavioural playback sequencer
   always @(negedge clk) begin
      done = 1'b0;
      if (!rst_n || abort || stop_o) begin
         busy = 1'b0; left = 0;
      end else if (start_o) begin
         busy = 1'b1; left = PLAY;
      end else if (busy) begin
         left--;
         if (left == 0) begin busy = 1'b0; done = 1'b1; end
      end
   end

   // reference model
   logic [8:0] m_cand, m_stab, m_prv, m_src;
   int m_cnt, m_cur, m_pg, m_ptr, m_grp;
   logic m_act, m_pend, m_start, m_stop;

   function automatic int key_group(logic [7:0] k);
      int pop = $countones(k);
      if (pop < 1 || pop > 4) return -1;
      for (int n = 0; n < 8; n++) begin
         logic [7:0] m = '0;
         for (int j = 0; j < pop; j++) m[(n + j) % 8] = 1'b1;
         if (m == k) return (pop - 1) * 8 + n;
      end
      return -1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cand = '0; m_stab = '0; m_prv = '0; m_src = '0; m_cnt = 0; m_cur = 0;
         m_pg = 0; m_ptr = 0; m_grp = 0; m_act = 0; m_pend = 0; m_start = 0; m_stop = 0;
      end else if (abort) begin
         m_stop = m_act; m_start = 0;
         m_cand = '0; m_stab = '0; m_prv = '0; m_src = '0; m_cnt = 0;
         m_act = 0; m_pend = 0; m_ptr = 0;
      end else begin
         logic [8:0] raw, o_stab, o_prv;
         int lim, g, kg, ng;
         logic press, seqp, rel, queue, go;
         m_start = 0; m_stop = 0;
         raw = {strobe, cpu ? (keys & 8'h1F) : keys};
         o_stab = m_stab; o_prv = m_prv;
         lim = busy ? LONG : SHORT;
         if (tick) begin
            if (raw != m_cand) begin m_cand = raw; m_cnt = 0; end
            else if (m_cnt < lim) m_cnt++;
            else m_stab = m_cand;
         end
         press = 0; seqp = 0; g = m_ptr;
         if (cpu) begin
            press = o_stab[8] && !o_prv[8]; g = int'(o_stab[4:0]);
         end else if (o_stab[7:0] != 0) begin
            kg = key_group(o_stab[7:0]);
            press = (o_stab[7:0] != o_prv[7:0]) && kg >= 0; g = (kg < 0) ? 0 : kg;
         end else begin
            press = o_stab[8] && !o_prv[8]; seqp = press;
         end
         rel   = m_act && o_prv == m_src && o_stab != m_src;
         queue = press && m_act && !RTG_OPT[g] && !EDGE_OPT[g] && !HOLD_OPT[g];
         go = 0; ng = g;
         if (press && (!m_act || RTG_OPT[g])) go = 1;
         else if (rel && HOLD_OPT[m_cur]) begin m_stop = 1; m_act = 0; m_pend = 0; end
         else if (done && m_act) begin
            if (m_pend || queue) begin go = 1; ng = queue ? g : m_pg; end
            else if (!EDGE_OPT[m_cur] && o_stab == m_src) begin go = 1; ng = m_cur; end
            else begin m_act = 0; m_pend = 0; end
         end else if (queue) begin m_pend = 1; m_pg = g; end
         if (go) begin
            m_start = 1; m_grp = ng; m_cur = ng; m_src = o_stab; m_act = 1; m_pend = 0;
         end
         m_prv = o_stab;
         if (seqp) m_ptr = (m_ptr + 1) % 32;
      end
   end

   // per-cycle compare
   always @(negedge clk) begin
      if (rst_n) begin
         vectors++;
         if (start_o !== m_start || stop_o !== m_stop || group_o !== 5'(m_grp)) begin
            errs++;
            $display("FAIL %s cycle compare: start/stop/grp act=%b/%b/%0d exp=%b/%b/%0d",
                     cur_req, start_o, stop_o, group_o, m_start, m_stop, m_grp);
         end
         if (start_o) begin n_start++; last_grp = int'(group_o); end
         if (stop_o) n_stop++;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_idle();
      wait_cyc(300);
      while (m_act) @(negedge clk);
      wait_cyc(300);
   endtask

   task automatic press_key(input logic [7:0] k, input int hold);
      @(negedge clk) keys = k;
      wait_cyc(hold);
      keys = '0;
   endtask

   task automatic press_lat(input logic [7:0] k, output int lat);
      int s0 = n_start;
      @(negedge clk) keys = k;
      lat = 0;
      while (n_start == s0 && lat < 2000) begin @(negedge clk); lat++; end
   endtask

   task automatic pulse_abort(input int n);
      @(negedge clk) abort = 1'b1;
      wait_cyc(n);
      abort = 1'b0;
   endtask

   task automatic seq_press();
      @(negedge clk) strobe = 1'b1;
      wait_cyc(220);
      strobe = 1'b0;
      wait_idle();
   endtask

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors + checks, errs);
      $finish;
   endtask

   initial begin
      #(180000 * 5);
      errs++;
      $display("FAIL watchdog: run did not finish act=1 exp=0");
      finish_run();
   end

   initial begin
      int s, t, lat_idle, lat_busy;
      wait_cyc(10);
      cur_req = "R12";
      chk("R12 reset start", int'(start_o), 0);
      chk("R12 reset stop", int'(stop_o), 0);
      chk("R12 reset group", int'(group_o), 0);
      @(negedge clk) rst_n = 1'b1;
      wait_cyc(20);

      cur_req = "R1";
      press_key(8'h01, 250); wait_idle();
      chk("R1 key0", last_grp, 0);
      press_key(8'h80, 250); wait_idle();
      chk("R1 key7", last_grp, 7);

      cur_req = "R2";
      press_key(8'h81, 250); wait_idle(); chk("R2 pair wrap", last_grp, 15);
      press_key(8'h07, 250); wait_idle(); chk("R2 triple", last_grp, 16);
      press_key(8'h83, 250); wait_idle(); chk("R2 triple wrap", last_grp, 23);
      press_key(8'hC3, 250); wait_idle(); chk("R2 quad wrap", last_grp, 30);
      s = n_start;
      press_key(8'h05, 250); wait_idle(); chk("R2 gap pattern", n_start, s);
      press_key(8'h1F, 250); wait_idle(); chk("R2 five keys", n_start, s);

      cur_req = "R5";
      s = n_start;
      press_key(8'h04, 100); wait_cyc(400);
      chk("R5 short glitch", n_start, s);
      for (int i = 0; i < 10; i++) begin
         @(negedge clk) keys = (i % 2 == 0) ? 8'h04 : 8'h00;
         wait_cyc(15);
      end
      press_key(8'h04, 250); wait_idle();
      chk("R5 bounce then hold", n_start, s + 1);

      cur_req = "R7";
      s = n_stop;
      press_key(8'h02, 400); wait_idle(); chk("R7 level hold release", n_stop, s + 1);
      press_key(8'h04, 400); wait_idle(); chk("R7 edge hold release", n_stop, s + 2);
      press_key(8'h01, 400); wait_idle(); chk("R7 unhold release", n_stop, s + 2);

      cur_req = "R8";
      s = n_start;
      press_lat(8'h10, lat_idle); wait_cyc(20); keys = '0; wait_cyc(300);
      cur_req = "R6";
      press_lat(8'h10, lat_busy); wait_cyc(20); keys = '0; wait_idle();
      chk("R8 retrigger restarts", n_start, s + 2);
      chk("R6 longer window busy", int'(lat_busy >= lat_idle + 60), 1);
      cur_req = "R8";
      s = n_start;
      press_key(8'h01, 200); wait_cyc(300); press_key(8'h01, 300); wait_idle();
      chk("R8 non-retrigger ignored", n_start, s + 1);

      cur_req = "R9";
      s = n_start;
      press_key(8'h08, 200); wait_cyc(300); press_key(8'h08, 800); wait_idle();
      chk("R9 pending start", n_start, s + 2);
      chk("R9 pending group", last_grp, 3);

      cur_req = "R10";
      s = n_start; t = n_stop;
      press_key(8'h02, 2500); wait_idle();
      chk("R10 level loop starts", n_start, s + 3);
      chk("R10 level loop stop", n_stop, t + 1);
      s = n_start;
      press_key(8'h01, 1500); wait_idle();
      chk("R10 edge no loop", n_start, s + 1);

      cur_req = "R11";
      s = n_start;
      @(negedge clk) keys = 8'h01;
      while (n_start == s) @(negedge clk);
      wait_cyc(30);
      s = n_start; t = n_stop;
      pulse_abort(10);
      chk("R11 abort stop", n_stop, t + 1);
      chk("R11 no start in abort", n_start, s);
      wait_cyc(100);
      chk("R11 debounce restarted", n_start, s);
      wait_cyc(200);
      chk("R11 held key restarts", n_start, s + 1);
      keys = '0; wait_idle();

      cur_req = "R4";
      pulse_abort(3); wait_cyc(10);
      seq_press(); chk("R4 seq first", last_grp, 0);
      seq_press(); chk("R4 seq second", last_grp, 1);
      pulse_abort(3); wait_cyc(10);
      for (int i = 0; i < 33; i++) begin
         seq_press();
         chk("R4 seq step/wrap", last_grp, i % 32);
      end

      cur_req = "R3";
      @(negedge clk) begin abort = 1'b1; cpu = 1'b1; end
      wait_cyc(5); abort = 1'b0;
      @(negedge clk) keys = 8'hB6;
      wait_cyc(20);
      strobe = 1'b1;
      for (int i = 0; i < 45; i++) begin
         @(negedge clk) keys[7:5] = 3'(i * 5);
         wait_cyc(4);
      end
      strobe = 1'b0; wait_idle();
      chk("R3 address latch", last_grp, 22);
      cur_req = "R4";
      @(negedge clk) keys = 8'h03;
      wait_cyc(20); strobe = 1'b1; wait_cyc(220); strobe = 1'b0; wait_idle();
      chk("R4 cpu strobe not sequential", last_grp, 3);
      finish_run();
   end
endmodule